// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked system bus read and write an external asynchronous static RAM of 131,072 bytes. The bus side is a plain request port: a request strobe with a write flag, a 17-bit address and a write byte. The controller answers every accepted request with a single-cycle done pulse. On a read, the fetched byte appears with that pulse.

On the memory side it drives the address, a chip-select pair (one active low, one active high), active-low write and read strobes, and a data bus split into an output value, an input value and an output-enable. Three wait-state parameters set the length of each phase:

- the number of read-access cycles;
- the width of the write strobe in cycles;
- the number of idle turnaround cycles after each transfer.

The integrator derives these from the clock period and the speed grade of the part. For example, a 12 ns part on a 100 MHz clock needs at least two read cycles.

Between transfers the controller keeps the memory in standby and drives nothing. It holds address and data for one cycle after the write strobe rises. It never drives the data pins while the memory's output driver can be on.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no transfer is in progress, the memory is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_wr_n`=1, `mem_rd_n`=1 and `mem_dq_oe`=0. After reset, `rsp_done`=0 and `rsp_rdata`=0.
- R2: `mem_sel` is always the inverse of `mem_sel_n`, so the part is either fully selected or in standby.
- R3: A read selects the memory with `mem_rd_n`=0, `mem_wr_n`=1 and `mem_dq_oe`=0. It holds the request address for exactly RD_WAIT consecutive cycles.
- R4: The byte on `mem_dq_in` in the last read cycle is presented on `rsp_rdata` in the following cycle. `rsp_rdata` keeps that value until the next read completes.
- R5: A write selects the memory with `mem_wr_n`=0, `mem_rd_n`=1, `mem_dq_oe`=1 and `mem_dq_out` equal to the request byte. This lasts exactly WR_WAIT consecutive cycles.
- R6: In the cycle after `mem_wr_n` rises, the selection, the address, `mem_dq_out` and `mem_dq_oe` are unchanged.
- R7: The controller never drives the bus (`mem_dq_oe`=1) while `mem_rd_n`=0. Every transfer is followed by TURN_WAIT cycles in the R1 idle state before the next transfer may begin.
- R8: Every accepted request produces exactly one `rsp_done` pulse, one cycle wide. For a read it comes RD_WAIT+1 cycles after acceptance; for a write it comes WR_WAIT+2 cycles after acceptance.
- R9: A request raised while a transfer or turnaround is in progress is ignored. It causes no memory cycle, no address change and no done pulse.
- R10: A request seen in the idle state is accepted on that clock edge, and the memory cycle starts in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transfer request, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address of the transfer |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Last byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Address to the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable of the memory |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Controller drives the data pins when 1 |

## Verification
The hardest situation to reach is a request arriving in the middle of a transfer or its turnaround. The bus side normally waits for done, so it never occurs in ordinary use. The bench forces it by raising a write request to a different address and byte for one cycle during a read or write. It then shows the stray request left no trace: the address stayed put, only one done pulse came, and a later read of the stray address returns its untouched contents. Back-to-back write-then-read pairs on the same address exercise the turnaround edge, while a behavioural memory model flags any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
// Shared types of the asynchronous SRAM controller.
// Assumes: one transfer in flight at a time.
package sram_ctrl_pkg;

    // Phases of one memory transfer
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_WRITE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_TURN  = 3'd4
    } phase_t;

endpackage

// File: rtl/sram_wait_cnt.sv
// Down-counter for wait states. A load sets the number of remaining cycles
// minus one; `last` flags the final cycle of the phase.
// Assumes: the load value fits CNT_W bits.
module sram_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
// Transfer sequencer: IDLE -> READ or WRITE -> (HOLD) -> TURN -> IDLE.
// Emits the strobes that latch a request, capture read data and finish.
// Assumes: RD_WAIT, WR_WAIT and TURN_WAIT are all at least 1.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_WAIT   = 2,
    parameter int WR_WAIT   = 2,
    parameter int TURN_WAIT = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             cnt_last,
    output phase_t           phase_d,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             accept,
    output logic             capture,
    output logic             finish
);

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_WAIT - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_WAIT - 1);

    phase_t phase_q;

    // Next-phase and strobe decode
    always_comb begin
        phase_d  = phase_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (req) begin
                accept   = 1'b1;
                cnt_load = 1'b1;
                phase_d  = req_we ? PH_WRITE : PH_READ;
                cnt_val  = req_we ? WR_LOAD : RD_LOAD;
            end
            PH_READ: if (cnt_last) begin
                capture  = 1'b1;
                finish   = 1'b1;
                cnt_load = 1'b1;
                cnt_val  = TURN_LOAD;
                phase_d  = PH_TURN;
            end
            PH_WRITE: if (cnt_last) phase_d = PH_HOLD;
            PH_HOLD: begin
                finish   = 1'b1;
                cnt_load = 1'b1;
                cnt_val  = TURN_LOAD;
                phase_d  = PH_TURN;
            end
            PH_TURN: if (cnt_last) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/sram_ctrl_pins.sv
// Request latch, read capture and registered memory-pin drive.
// Pins are decoded from the next phase and registered, so they change
// together with the phase and carry no decode glitches.
// Assumes: accept, capture and finish come from sram_ctrl_seq.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_d,
    input  logic              accept,
    input  logic              capture,
    input  logic              finish,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    logic sel_nxt;

    assign sel_nxt = (phase_d == PH_READ) || (phase_d == PH_WRITE) ||
                     (phase_d == PH_HOLD);

    // Latch address and write byte when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Capture read data and raise the one-cycle done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_done  <= 1'b0;
        end else begin
            rsp_done <= finish;
            if (capture) rsp_rdata <= mem_dq_in;
        end
    end

    // Registered memory control pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_wr_n  <= 1'b1;
            mem_rd_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_sel_n <= !sel_nxt;
            mem_sel   <= sel_nxt;
            mem_wr_n  <= (phase_d != PH_WRITE);
            mem_rd_n  <= (phase_d != PH_READ);
            mem_dq_oe <= (phase_d == PH_WRITE) || (phase_d == PH_HOLD);
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous SRAM controller: joins the sequencer, the
// wait-state counter and the pin stage.
// Assumes: wait-state parameters are >= 1 and chosen from clock period
// and part speed; the requester waits for rsp_done between requests.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int RD_WAIT   = 2,
    parameter int WR_WAIT   = 2,
    parameter int TURN_WAIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int MAX_RW  = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int MAX_ALL = (MAX_RW > TURN_WAIT) ? MAX_RW : TURN_WAIT;
    localparam int CNT_W   = (MAX_ALL > 1) ? $clog2(MAX_ALL) : 1;

    phase_t           phase_d;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_last;
    logic             accept;
    logic             capture;
    logic             finish;

    sram_ctrl_seq #(
        .RD_WAIT   (RD_WAIT),
        .WR_WAIT   (WR_WAIT),
        .TURN_WAIT (TURN_WAIT),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_we   (req_we),
        .cnt_last (cnt_last),
        .phase_d  (phase_d),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .accept   (accept),
        .capture  (capture),
        .finish   (finish)
    );

    sram_wait_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    sram_ctrl_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_d    (phase_d),
        .accept     (accept),
        .capture    (capture),
        .finish     (finish),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_wr_n   (mem_wr_n),
        .mem_rd_n   (mem_rd_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for the SRAM controller pins, bound to the top module.
// Assumes: only the top-level ports are visible.
module sram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel |-> (mem_rd_n && mem_wr_n && !mem_dq_oe)); // R1

    AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel == !mem_sel_n); // R2

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n)); // R3

    AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && !$past(mem_rd_n)) |-> $stable(mem_addr)); // R3

    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_dq_oe && mem_sel)); // R5

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (mem_sel && mem_dq_oe && $stable(mem_addr)
                             && $stable(mem_dq_out))); // R6

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_dq_oe); // R7

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> !$past(mem_dq_oe)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_done   (rsp_done),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_wr_n   (mem_wr_n),
    .mem_rd_n   (mem_rd_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
// Self-checking bench: behavioural SRAM model, timing sweep over many
// addresses, turnaround pairs and requests injected while busy.
module sram_async_ctrl_tb;

    localparam int RD   = 3;
    localparam int WR   = 2;
    localparam int TURN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int fails = 0;
    int contention = 0;
    int cyc = 0;
    logic [7:0] last_rd = '0;

    logic [7:0] model_mem [int];
    logic [7:0] exp_mem [int];

    always #4 clk = ~clk; // 125 MHz

    sram_async_ctrl #(
        .RD_WAIT (RD), .WR_WAIT (WR), .TURN_WAIT (TURN)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req (req), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata), .rsp_done (rsp_done),
        .mem_addr (mem_addr), .mem_sel_n (mem_sel_n), .mem_sel (mem_sel),
        .mem_wr_n (mem_wr_n), .mem_rd_n (mem_rd_n),
        .mem_dq_out (mem_dq_out), .mem_dq_in (mem_dq_in),
        .mem_dq_oe (mem_dq_oe)
    );

    function automatic logic [7:0] dflt(input logic [16:0] a);
        return (a[7:0] ^ a[16:9]) + 8'h3C;
    endfunction

    function automatic logic [7:0] exp_of(input logic [16:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: drive read data, and flag contention
    always @(negedge clk) begin
        logic drv;
        drv = rst_n && !mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n;
        if (drv && mem_dq_oe) contention++;
        if (drv)
            mem_dq_in <= model_mem.exists(int'(mem_addr)) ?
                         model_mem[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_dq_in <= 8'h00;
    end

    // Memory model: store on the rising write strobe while selected
    always @(posedge mem_wr_n) begin
        if (rst_n && mem_sel === 1'b1 && mem_sel_n === 1'b0) begin
            if (mem_dq_oe !== 1'b1) contention++;
            model_mem[int'(mem_addr)] = mem_dq_out;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    // One transfer with cycle-by-cycle pin checks; optional busy-time request
    task automatic run_op(input bit we, input logic [16:0] a,
                          input logic [7:0] d, input bit inject);
        int  dn;
        int  dones;
        bit  bad_rw, bad_pair, bad_idle, bad_addr, bad_data;
        logic [7:0] expd;
        dn = we ? WR + 2 : RD + 1;
        dones = 0;
        bad_rw = 0; bad_pair = 0; bad_idle = 0; bad_addr = 0; bad_data = 0;
        expd = we ? 8'h00 : exp_of(a);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        for (int n = 1; n <= dn + TURN; n++) begin
            bit sel_e, rd_e, wr_e, oe_e;
            @(negedge clk);
            sel_e = we ? (n <= WR + 1) : (n <= RD);
            rd_e  = !we && (n <= RD);
            wr_e  = we && (n <= WR);
            oe_e  = we && (n <= WR + 1);
            if (n == 1)
                check(mem_sel && (we ? !mem_wr_n : !mem_rd_n), "R10 cycle start",
                      {mem_sel, mem_wr_n, mem_rd_n}, {1'b1, !we, we});
            if (mem_sel == mem_sel_n) bad_pair = 1;
            if (sel_e) begin
                if (mem_sel != 1'b1 || mem_rd_n != !rd_e || mem_wr_n != !wr_e ||
                    mem_dq_oe != oe_e) bad_rw = 1;
                if (mem_addr != a) bad_addr = 1;
                if (we && mem_dq_out != d) bad_data = 1;
            end else if (mem_sel || !mem_rd_n || !mem_wr_n || mem_dq_oe) begin
                bad_idle = 1;
            end
            if (we && n == WR + 1)
                check(mem_wr_n && mem_sel && mem_dq_oe && mem_addr == a &&
                      mem_dq_out == d, "R6 hold after strobe",
                      {mem_wr_n, mem_sel, mem_dq_oe}, 3'b111);
            if (rsp_done) begin
                dones++;
                check(n == dn, "R8 done latency", n, dn);
                if (!we) begin
                    check(rsp_rdata == expd, "R4 read data", rsp_rdata, expd);
                    last_rd = expd;
                end else begin
                    check(rsp_rdata == last_rd, "R4 read data held", rsp_rdata, last_rd);
                end
            end
            // R9 stimulus: a stray write request while busy
            if (n == 1) req = inject;
            if (inject) begin
                req_we = 1'b1; req_addr = a ^ 17'h00155; req_wdata = ~d;
            end
            if (n == 2) req = 1'b0;
        end
        if (we) check(!bad_rw, "R5 write strobe window", bad_rw, 0);
        else    check(!bad_rw, "R3 read window", bad_rw, 0);
        check(!bad_pair, "R2 select pair", bad_pair, 0);
        check(!bad_idle, "R7 turnaround idle", bad_idle, 0);
        check(!bad_addr, inject ? "R9 address unchanged" : "R3 address held", bad_addr, 0);
        if (we) check(!bad_data, "R5 write byte", bad_data, 0);
        check(dones == 1, inject ? "R9 single done" : "R8 one done", dones, 1);
        if (we) exp_mem[int'(a)] = d;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe,
              "R1 reset standby", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe},
              5'b10110);
        check(!rsp_done && rsp_rdata == 8'h00, "R1 reset outputs", rsp_rdata, 0);

        // Reads of untouched locations, including both address ends
        run_op(1'b0, 17'h00000, 8'h00, 1'b0);
        run_op(1'b0, 17'h1FFFF, 8'h00, 1'b0);
        run_op(1'b0, 17'h0AAAA, 8'h00, 1'b0);

        // Write sweep then read-back sweep
        for (int i = 0; i < 48; i++)
            run_op(1'b1, 17'((i * 2731) + (i == 47 ? 17'h1FFFF : 0)), 8'(i * 37 + 5), 1'b0);
        for (int i = 0; i < 48; i++)
            run_op(1'b0, 17'((i * 2731) + (i == 47 ? 17'h1FFFF : 0)), 8'h00, 1'b0);

        // Write-then-read pairs on one address: turnaround in both directions
        for (int i = 0; i < 16; i++) begin
            run_op(1'b1, 17'(17'h10000 + i * 97), 8'(8'hA0 ^ i), 1'b0);
            run_op(1'b0, 17'(17'h10000 + i * 97), 8'h00, 1'b0);
        end

        // Stray requests while busy, then read the stray target back
        for (int i = 0; i < 8; i++) begin
            logic [16:0] a;
            a = 17'(17'h04000 + i * 513);
            run_op(i[0], a, 8'(8'h5A + i), 1'b1);
            run_op(1'b0, a ^ 17'h00155, 8'h00, 1'b0);
        end

        check(contention == 0, "R7 no bus contention", contention, 0);
        summary();
        $finish;
    end

endmodule